// File: doc/BRIEF.md
# Synchronous Byte-Load Configuration Port

This block is the slave end of a configuration link. A host drives a configuration clock and puts 8-bit data on a parallel bus. The port takes bytes at fixed rising-edge positions, counted from the moment an init-done input is seen high. The host never waits: there is no busy state. Each capture produces a one-period acknowledge pulse. It also produces a byte-valid strobe carrying the captured value.

Every captured byte is loaded in parallel into a shift register. The register runs on the falling edge of the same clock, so the first serial bit appears half a period after the capture. The byte then leaves most-significant bit first on a serial output, which can feed a further device in a daisy chain. The shifting carries on as long as the clock toggles and no new capture is needed for it.

The clock is supplied from outside and is limited to 8 MHz, with a high time of at least 50 ns and a low time of at least 60 ns. Setup and hold timing of the bus and the device's configuration memory are outside this block.

Top module: `cfgport_top`

## Requirements
- R1: While reset is asserted or init_done is low, ack and byte_vld are 0 and sdo is 1.
- R2: The first byte is captured on the second consecutive rising edge at which init_done is sampled high. The edge at which init_done is first seen high never captures.
- R3: After a capture, the next capture happens on the 8th following rising edge, as long as init_done stays high.
- R4: ack is 1 for exactly the one clock period that follows a capturing rising edge, and 0 otherwise.
- R5: byte_vld is 1 in the same period as ack. byte_q then holds the value that din had at the capturing edge.
- R6: The falling edge inside the period that follows a capture loads the byte into the shifter. sdo then shows bit 7 of the byte, and each later falling edge moves sdo on by one bit, down to bit 0.
- R7: Once a byte is loaded, its remaining seven bits come out on the next seven falling edges, whatever values din takes meanwhile.
- R8: When init_done goes low, the falling edge that samples it low aborts any byte in flight and forces sdo to 1. The edge count restarts, so the next capture is again on the 2nd high edge.
- R9: A new byte is loaded only once all 8 bits of the previous byte have been shifted out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_clk | input | 1 | Externally supplied configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_done | input | 1 | High when the device is ready to accept bytes |
| din | input | 8 | Parallel data bus from the host |
| ack | output | 1 | One-period pulse after each captured byte |
| sdo | output | 1 | Serial data out, MSB first, idle high |
| byte_vld | output | 1 | Strobe marking byte_q as a fresh capture |
| byte_q | output | 8 | Most recently captured byte |

## Verification
The hardest case to reach from the ports is init_done falling while a byte is only part-way through the falling-edge shifter. The aborted byte has to vanish from sdo, and the restarted edge count must not reload the shifter at a stale phase. The stimulus drops init_done a few periods after a capture, and then applies init pulses of one and two edges. The last of these ends right after its capture. Separately, all 256 byte values are streamed back to back, so every bit position is seen at both levels, with different values on din between the capture edges.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  // Non-capturing high edges that precede the first capture.
  function automatic int unsigned lead_skip(int unsigned first_edge);
    return (first_edge > 0) ? first_edge - 1 : 0;
  endfunction

  // Non-capturing edges between two captures spaced 'period' apart.
  function automatic int unsigned gap_skip(int unsigned period);
    return (period > 0) ? period - 1 : 0;
  endfunction

  // Width of a counter that has to hold values up to 'maxv'.
  function automatic int unsigned cnt_width(int unsigned maxv);
    return (maxv < 2) ? 1 : $clog2(maxv + 1);
  endfunction

endpackage

// File: rtl/cfgport_timer.sv
module cfgport_timer
  import cfgport_pkg::*;
#(
  parameter int unsigned FIRST_EDGE = 2,
  parameter int unsigned PERIOD     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  output logic capture
);
  localparam int unsigned LEAD   = lead_skip(FIRST_EDGE);
  localparam int unsigned GAP    = gap_skip(PERIOD);
  localparam int unsigned MAXV   = (LEAD > GAP) ? LEAD : GAP;
  localparam int unsigned SKIP_W = cnt_width(MAXV);
  localparam logic [SKIP_W-1:0] LEAD_V = SKIP_W'(LEAD);
  localparam logic [SKIP_W-1:0] GAP_V  = SKIP_W'(GAP);

  logic [SKIP_W-1:0] skip_q;

  assign capture = init && (skip_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       skip_q <= LEAD_V;
    else if (!init)   skip_q <= LEAD_V;
    else if (capture) skip_q <= GAP_V;
    else              skip_q <= skip_q - 1'b1;
  end

  p_no_cap_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !init |-> !capture);

  p_first_edge_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (init && !$past(init)) |-> !capture);

  p_cap_spaced_r3: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> !capture);

endmodule

// File: rtl/cfgport_shift.sv
module cfgport_shift
  import cfgport_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              load_req,
  input  logic [DATA_W-1:0] load_data,
  output logic              sdo,
  output logic              empty
);
  localparam int unsigned LEFT_W = cnt_width(DATA_W - 1);
  localparam logic [LEFT_W-1:0] LAST = LEFT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q;
  logic [LEFT_W-1:0] left_q;
  logic              load;

  assign empty = (left_q == '0);
  assign load  = load_req && empty;
  assign sdo   = sh_q[DATA_W-1];

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      left_q <= '0;
    end else if (!init) begin
      sh_q   <= '1;
      left_q <= '0;
    end else if (load) begin
      sh_q   <= load_data;
      left_q <= LAST;
    end else begin
      sh_q   <= {sh_q[DATA_W-2:0], 1'b1};
      if (!empty) left_q <= left_q - 1'b1;
    end
  end

  p_reload_empty_r9: assert property (@(negedge clk) disable iff (!rst_n)
    (init && load_req) |-> empty);

  p_idle_high_r1: assert property (@(negedge clk) disable iff (!rst_n)
    !init |=> sdo);

endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
  import cfgport_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned FIRST_EDGE = 2
) (
  input  logic              cfg_clk,
  input  logic              rst_n,
  input  logic              init_done,
  input  logic [DATA_W-1:0] din,
  output logic              ack,
  output logic              sdo,
  output logic              byte_vld,
  output logic [DATA_W-1:0] byte_q
);
  localparam int unsigned PERIOD = DATA_W;

  logic              capture;
  logic              shift_empty;
  logic              ack_q;
  logic              vld_q;
  logic [DATA_W-1:0] cap_q;

  cfgport_timer #(.FIRST_EDGE(FIRST_EDGE), .PERIOD(PERIOD)) timer_i (
    .clk     (cfg_clk),
    .rst_n   (rst_n),
    .init    (init_done),
    .capture (capture)
  );

  always_ff @(posedge cfg_clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      vld_q <= 1'b0;
      cap_q <= '0;
    end else begin
      ack_q <= capture;
      vld_q <= capture;
      if (capture) cap_q <= din;
    end
  end

  cfgport_shift #(.DATA_W(DATA_W)) shift_i (
    .clk       (cfg_clk),
    .rst_n     (rst_n),
    .init      (init_done),
    .load_req  (vld_q),
    .load_data (cap_q),
    .sdo       (sdo),
    .empty     (shift_empty)
  );

  assign ack      = ack_q;
  assign byte_vld = vld_q;
  assign byte_q   = cap_q;

  p_ack_pulse_r4: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    ack |=> !ack);

  p_vld_holds_din_r5: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    capture |=> (byte_vld && byte_q == $past(din)));

  p_low_init_quiet_r1: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    !init_done |=> (!ack && !byte_vld));

endmodule

// File: tb/cfgport_top_tb_top.sv
module cfgport_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       init_done;
  logic [7:0] din;
  logic       ack, sdo, byte_vld;
  logic [7:0] byte_q;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // Reference model state
  int         hi_edges = 0;
  int         k_bits   = 99;
  logic [7:0] sh_byte  = 8'hFF;

  always #4 clk = ~clk;

  cfgport_top dut_i (
    .cfg_clk(clk), .rst_n(rst_n), .init_done(init_done), .din(din),
    .ack(ack), .sdo(sdo), .byte_vld(byte_vld), .byte_q(byte_q)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h t=%0t", req, got, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Drive inputs, take one rising edge, then check 6 ns later (after the falling edge).
  task automatic step(input logic i, input logic [7:0] d);
    bit cap;
    logic exp_sdo;
    init_done = i;
    din = d;
    @(posedge clk);
    if (i) begin
      hi_edges++;
      cap = (hi_edges >= 2) && (((hi_edges - 2) % 8) == 0);
    end else begin
      hi_edges = 0;
      cap = 0;
    end
    if (!i) k_bits = 99;
    else if (cap) begin k_bits = 0; sh_byte = d; end
    else if (k_bits < 99) k_bits++;
    exp_sdo = (k_bits < 8) ? sh_byte[7 - k_bits] : 1'b1;
    #6;
    chk("R4 ack", {7'd0, ack}, {7'd0, cap});
    chk((cap && hi_edges == 2) ? "R2 first capture" : "R3 capture spacing",
        {7'd0, byte_vld}, {7'd0, cap});
    if (cap) chk("R5 byte_q", byte_q, d);
    chk(!i ? "R8 init low sdo" : (k_bits == 0 ? "R6 first bit" : "R7 shift"),
        {7'd0, sdo}, {7'd0, exp_sdo});
  endtask

  initial begin
    #2_000_000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; init_done = 1'b0; din = 8'h00;
    repeat (3) @(posedge clk);
    #6;
    chk("R1 reset ack", {7'd0, ack}, 8'd0);
    chk("R1 reset vld", {7'd0, byte_vld}, 8'd0);
    chk("R1 reset sdo", {7'd0, sdo}, 8'd1);
    #4 rst_n = 1'b1;
    #4;

    // R1: init held low after reset, with din toggling
    for (int c = 0; c < 4; c++) step(1'b0, 8'(c * 91 + 3));

    // R2/R3/R5/R6/R7: all 256 byte values streamed, din varies between captures
    step(1'b1, 8'hA5);
    for (int b = 0; b < 256; b++)
      for (int p = 0; p < 8; p++)
        step(1'b1, (p == 0) ? 8'(b) : 8'(~b ^ (p * 37)));

    // R8: drop init three bits into a byte, then restart
    for (int c = 0; c < 2; c++) step(1'b0, 8'h00);
    for (int c = 0; c < 13; c++) step(1'b1, 8'(c * 53 + 1));
    for (int c = 0; c < 3; c++) step(1'b0, 8'hFF);

    // R2: one-edge init pulse gives no capture, two-edge pulse gives one
    step(1'b1, 8'h3C);
    step(1'b0, 8'h00);
    step(1'b1, 8'h11);
    step(1'b1, 8'hC3);
    for (int c = 0; c < 3; c++) step(1'b0, 8'h00);

    // R7/R9: long run with constant din after the final restart
    for (int c = 0; c < 30; c++) step(1'b1, (c == 1) ? 8'h96 : 8'h00);
    for (int c = 0; c < 2; c++) step(1'b0, 8'h00);

    finish_run();
  end
endmodule